// File: doc/BRIEF.md
# Sync Header Error-Rate Monitor

This block sits on the receive side of a 64B/66B physical coding sublayer. For every received block it looks at one bit that says whether the two-bit sync header was legal. A header is legal when it is 01 or 10. The block counts the blocks whose header was illegal. The count is taken over a fixed observation window of 125 microseconds. When a window holds more than sixteen illegal headers, the block raises a level flag that tells the fabric the link has a high bit error rate.

The window is set in clock cycles by `WINDOW_CYCLES`, which is the clock frequency times 125 us. At 200 MHz that is 25000 cycles. The counter only runs while the upstream block-lock indication is high. Losing lock clears the counter, the window timer and the flag. The current count is also exposed on a port so that its progress within the window can be observed.

Top module: `shber_monitor`

## Requirements
- R1: After reset, `hi_ber_o` is 0 and `err_cnt_o` is 0.
- R2: While locked, each clock edge on which `blk_vld_i` is 1 and `hdr_ok_i` is 0 adds exactly one to `err_cnt_o`. Here `hdr_ok_i` = 1 means the header was 01 or 10, and 0 means it was 00 or 11.
- R3: A clock edge with `blk_vld_i` = 0 leaves `err_cnt_o` unchanged, whatever the value of `hdr_ok_i`. A block with `hdr_ok_i` = 1 also leaves it unchanged.
- R4: While `lock_i` is 0, the block counts nothing. After the next edge, `err_cnt_o` is 0 and `hi_ber_o` is 0.
- R5: `hi_ber_o` rises on the same edge at which `err_cnt_o` goes from 16 to 17. Whenever `err_cnt_o` is above 16, `hi_ber_o` is 1.
- R6: A window that ends with exactly 16 illegal headers never raises `hi_ber_o`.
- R7: On the last edge of a window, `err_cnt_o` returns to 0, and the next window starts counting from zero.
- R8: When a window ends above 16, `hi_ber_o` stays at 1 across that boundary. It falls only on the last edge of a later window that ends at or below 16, or when lock is lost.
- R9: `err_cnt_o` saturates at 2^`CNT_W`-1 and never wraps within a window.
- R10: A window lasts `WINDOW_CYCLES` edges with lock high. The first window starts on the first edge at which `lock_i` is seen high, and the timer restarts whenever lock is regained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_i | input | 1 | Block lock achieved |
| blk_vld_i | input | 1 | A block (and its header status) is present this cycle |
| hdr_ok_i | input | 1 | 1 when the sync header is 01 or 10 |
| hi_ber_o | output | 1 | High bit-error-rate level flag |
| err_cnt_o | output | CNT_W | Illegal headers counted in the current window |

## Verification
The hardest behaviour to reach from the ports is the flag outliving a window boundary and then clearing only when a later clean window closes. A related hard case is counter saturation, which needs more illegal headers in one window than the counter can hold. The bench shortens the window to 80 cycles. It counts clock edges from the rise of lock, so it knows exactly which edge closes each window. It then places bursts of illegal headers of chosen lengths (16, 17 and 70) inside consecutive windows. Lock is also dropped part way through a window to show that the timer restarts.

// File: rtl/shber_pkg.sv
package shber_pkg;

  // Increment v by one when inc is set, but never beyond maxv.
  function automatic int unsigned sat_inc(input int unsigned v, input bit inc,
                                          input int unsigned maxv);
    if (!inc || v >= maxv) return v;
    return v + 1;
  endfunction

  // True when a window total lies strictly above the allowed number.
  function automatic bit above_limit(input int unsigned total,
                                     input int unsigned limit);
    return total > limit;
  endfunction

endpackage

// File: rtl/shber_window_timer.sv
module shber_window_timer #(
  parameter int unsigned WINDOW_CYCLES = 25000,
  localparam int unsigned TMR_W = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_i,
  output logic win_end_o
);
  localparam logic [TMR_W-1:0] LAST = TMR_W'(WINDOW_CYCLES - 1);

  logic [TMR_W-1:0] tmr_q;
  logic             at_last;

  assign at_last   = (tmr_q == LAST);
  assign win_end_o = lock_i && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n || !lock_i) tmr_q <= '0;
    else if (at_last)      tmr_q <= '0;
    else                   tmr_q <= tmr_q + 1'b1;
  end
endmodule

// File: rtl/shber_err_counter.sv
module shber_err_counter #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_i,
  input  logic             bad_i,
  input  logic             win_end_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] total_o
);
  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] cnt_q;

  assign total_o = CNT_W'(shber_pkg::sat_inc(32'(cnt_q), bad_i, CNT_MAX));
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !lock_i) cnt_q <= '0;
    else if (win_end_i)    cnt_q <= '0;
    else                   cnt_q <= total_o;
  end
endmodule

// File: rtl/shber_flag.sv
module shber_flag #(
  parameter int unsigned CNT_W     = 6,
  parameter int unsigned HI_THRESH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_i,
  input  logic             win_end_i,
  input  logic [CNT_W-1:0] total_i,
  output logic             hi_ber_o
);
  logic over;

  assign over = shber_pkg::above_limit(32'(total_i), HI_THRESH);

  always_ff @(posedge clk) begin
    if (!rst_n || !lock_i) hi_ber_o <= 1'b0;
    else if (win_end_i)    hi_ber_o <= over;
    else if (over)         hi_ber_o <= 1'b1;
  end
endmodule

// File: rtl/shber_monitor.sv
module shber_monitor #(
  parameter int unsigned WINDOW_CYCLES = 25000,
  parameter int unsigned HI_THRESH     = 16,
  parameter int unsigned CNT_W         = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_i,
  input  logic             blk_vld_i,
  input  logic             hdr_ok_i,
  output logic             hi_ber_o,
  output logic [CNT_W-1:0] err_cnt_o
);
  logic             win_end_w;
  logic             bad_hdr_w;
  logic [CNT_W-1:0] total_w;

  // An illegal header counts only on a valid block while locked.
  assign bad_hdr_w = lock_i && blk_vld_i && !hdr_ok_i;

  shber_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .win_end_o(win_end_w)
  );

  shber_err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .bad_i(bad_hdr_w),
    .win_end_i(win_end_w), .cnt_o(err_cnt_o), .total_o(total_w)
  );

  shber_flag #(.CNT_W(CNT_W), .HI_THRESH(HI_THRESH)) u_flag (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .win_end_i(win_end_w),
    .total_i(total_w), .hi_ber_o(hi_ber_o)
  );
endmodule

// File: rtl/shber_checker.sv
module shber_checker #(
  parameter int unsigned HI_THRESH = 16,
  parameter int unsigned CNT_W     = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lock_i,
  input logic             blk_vld_i,
  input logic             hdr_ok_i,
  input logic             win_end,
  input logic             hi_ber_o,
  input logic [CNT_W-1:0] err_cnt_o
);
  localparam logic [CNT_W-1:0] MAXV = '1;
  localparam logic [CNT_W-1:0] LIM  = CNT_W'(HI_THRESH);

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_i && !win_end && blk_vld_i && !hdr_ok_i && err_cnt_o != MAXV)
      |=> err_cnt_o == $past(err_cnt_o) + 1'b1);

  a_r3_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_i && !win_end && !(blk_vld_i && !hdr_ok_i)) |=> $stable(err_cnt_o));

  a_r4_unlock_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_i |=> (err_cnt_o == '0 && !hi_ber_o));

  a_r5_flag_above: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt_o > LIM) |-> hi_ber_o);

  a_r7_window_clear: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> err_cnt_o == '0);

  a_r8_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_ber_o && lock_i && !win_end) |=> hi_ber_o);

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_i && !win_end && err_cnt_o == MAXV) |=> err_cnt_o == MAXV);
endmodule

bind shber_monitor shber_checker #(.HI_THRESH(HI_THRESH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .blk_vld_i(blk_vld_i),
  .hdr_ok_i(hdr_ok_i), .win_end(win_end_w), .hi_ber_o(hi_ber_o),
  .err_cnt_o(err_cnt_o)
);

// File: tb/sim_shber_monitor.sv
`timescale 1ns/1ps
module sim_shber_monitor;
  localparam int W  = 80;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0, lock = 1'b0, vld = 1'b0, ok = 1'b1;
  logic hi;
  logic [CW-1:0] cnt;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  shber_monitor #(.WINDOW_CYCLES(W), .HI_THRESH(16), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .lock_i(lock), .blk_vld_i(vld),
    .hdr_ok_i(ok), .hi_ber_o(hi), .err_cnt_o(cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock edge with the given block inputs; returns at the next negedge.
  task automatic step(input logic v, input logic k, input int n = 1);
    for (int i = 0; i < n; i++) begin
      vld = v; ok = k;
      @(negedge clk);
    end
    vld = 1'b0; ok = 1'b1;
  endtask

  task automatic t_reset;
    chk("R1 flag", hi, 0);
    chk("R1 count", cnt, 0);
  endtask

  task automatic t_unlocked;
    lock = 1'b0;
    step(1, 0, 10);
    chk("R4 count unlocked", cnt, 0);
    chk("R4 flag unlocked", hi, 0);
  endtask

  task automatic t_basic_count;
    lock = 1'b1;
    step(1, 0, 5);
    chk("R2 five bad", cnt, 5);
    step(0, 0, 3);
    chk("R3 vld low ignored", cnt, 5);
    step(1, 1, 3);
    chk("R3 good header ignored", cnt, 5);
    step(0, 1, W - 12);
    chk("R10 count before last edge", cnt, 5);
    step(0, 1);
    chk("R7 cleared at window end", cnt, 0);
    chk("R6 low flag", hi, 0);
  endtask

  task automatic t_exact16;
    step(1, 0, 16);
    chk("R6 count 16", cnt, 16);
    chk("R6 no flag at 16", hi, 0);
    step(0, 1, W - 16);
    chk("R6 no flag after window", hi, 0);
    chk("R7 clear", cnt, 0);
  endtask

  task automatic t_over17;
    step(1, 0, 16);
    chk("R5 flag low at 16", hi, 0);
    step(1, 0);
    chk("R5 count 17", cnt, 17);
    chk("R5 flag at 17", hi, 1);
    step(0, 1, W - 17);
    chk("R8 flag kept over boundary", hi, 1);
    chk("R7 clear after busy window", cnt, 0);
    step(0, 1, W - 1);
    chk("R8 flag held in clean window", hi, 1);
    step(0, 1);
    chk("R8 flag cleared after clean window", hi, 0);
  endtask

  task automatic t_saturate;
    step(1, 0, 70);
    chk("R9 saturated", cnt, 63);
    chk("R5 flag on", hi, 1);
    step(0, 1, W - 70);
    chk("R7 clear from saturation", cnt, 0);
    chk("R8 flag kept", hi, 1);
    lock = 1'b0;
    step(0, 1);
    chk("R4 flag dropped on lock loss", hi, 0);
    chk("R4 count dropped", cnt, 0);
  endtask

  task automatic t_relock;
    lock = 1'b1;
    step(0, 1, 50);
    lock = 1'b0;
    step(0, 1);
    lock = 1'b1;
    step(1, 0, 3);
    step(0, 1, W - 4);
    chk("R10 window restarted on relock", cnt, 3);
    step(0, 1);
    chk("R10 boundary W edges after relock", cnt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unlocked();
    t_basic_count();
    t_exact16();
    t_over17();
    t_saturate();
    t_relock();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule